// File: doc/BRIEF.md
# Sense-Configurable External Interrupt Controller

This block watches eight external interrupt pins and one non-maskable pin, turns the activity on them into latched requests, and forwards one request line per pin (plus one for the non-maskable pin) to a parent interrupt controller. Each of the eight pins has its own two-bit sense selection: active-low level, falling edge, rising edge, or either edge. The non-maskable pin is always edge-sensed, and one control bit chooses the polarity.

All pins pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier. The synchroniser flops preset high, which is the idle level of every default mode, so releasing reset with idle pins raises no request. Software reads and writes 16-bit registers on a plain select/write/address bus. Reads are combinational on the address and writes take effect at the clock edge where select and write are both high. The bus has no back-pressure. Request bits are cleared by writing 0 to them, and any bit written as 1 keeps its value. To drop one request, software writes all ones except the target bit. A request arriving in the same cycle as a clear wins, so a pin held low in level mode sets its bit again at once.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The sense register at byte offset 2 holds a 2-bit mode for pin n in bits [2n+1:2n]. Writes to it read back unchanged.
- R2: Mode 0 (level): request bit n is set in every cycle in which the synchronised pin is low, including the cycle of a clear.
- R3: Mode 1 (falling): request bit n is set on a synchronised high-to-low transition only.
- R4: Mode 2 (rising): request bit n is set on a synchronised low-to-high transition only.
- R5: Mode 3 (both): request bit n is set on either transition.
- R6: The request register at byte offset 4 holds bit n for pin n. A write clears every bit written as 0 and keeps every bit written as 1. Bits 15:8 read 0.
- R7: irq_req[n] is high exactly while request bit n is set, and nmi_req is high exactly while the non-maskable flag is set.
- R8: Bit 15 of the control register at byte offset 0 reads the synchronised non-maskable pin level and ignores writes. Bits other than 15, 8 and 1 read 0 and ignore writes.
- R9: Control bit 8 selects the non-maskable edge (0 falling, 1 rising). Control bit 1 is the flag, set when the selected edge is seen.
- R10: Writing 0 to control bit 1 clears the flag, and writing 1 keeps it.
- R11: Reset clears the sense field, the request bits, the edge select and the flag. All request outputs are low during reset.
- R12: A pin change presented before clock edge k shows on the request output after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | External interrupt pins, asynchronous |
| nmi_pin | input | 1 | Non-maskable pin, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_req | output | 8 | Per-pin request lines to the parent |
| nmi_req | output | 1 | Non-maskable request line |

## Verification
The bench puts all four sense modes side by side on different pins and drives one shared waveform, so a swapped mode code or a sense field at the wrong bit position shows up as the wrong request pattern. It clears requests while a level-mode pin is still held low. A design that lets the clear win would drop that bit, and one that ignored the written ones would lose the neighbouring bits. It measures the latency of a single edge to the exact cycle, which catches a missing or extra synchroniser stage. It also checks that the non-maskable flag follows only the selected polarity, and that bit 15 and the unused control bits ignore written ones.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_SENSE = 2;
  localparam int unsigned OFS_REQ   = 4;

  localparam int unsigned CTRL_LVL_BIT  = 15;
  localparam int unsigned CTRL_EDGE_BIT = 8;
  localparam int unsigned CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] last
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] last_q;

  // Preset high: the idle level of every default sense mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      cur_q  <= '1;
      last_q <= '1;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      last_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign last = last_q;

  // R12: each stage adds exactly one cycle
  assert_two_stage_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q == $past(meta_q));
  assert_prev_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
    last_q == $past(cur_q));
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   cur,
  input  logic [N-1:0]   last,
  input  logic [2*N-1:0] sense_flat,
  output logic [N-1:0]   hit
);
  for (genvar g = 0; g < N; g++) begin : g_chan
    sense_e mode;
    logic   fell;
    logic   rose;
    assign mode = sense_e'(sense_flat[2*g +: 2]);
    assign fell = last[g] & ~cur[g];
    assign rose = ~last[g] & cur[g];
    always_comb begin
      unique case (mode)
        SENSE_LOW:  hit[g] = ~cur[g];
        SENSE_FALL: hit[g] = fell;
        SENSE_RISE: hit[g] = rose;
        SENSE_BOTH: hit[g] = fell | rose;
        default:    hit[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N-1:0]      irq_hit,
  input  logic              nmi_cur,
  input  logic              nmi_last,
  output logic [2*N-1:0]    sense_flat,
  output logic [N-1:0]      req,
  output logic              nmi_flag
);
  localparam int unsigned SW = 2 * N;

  logic [SW-1:0] sense_q;
  logic [N-1:0]  req_q;
  logic          edge_sel_q;
  logic          flag_q;
  logic          wr_ctrl, wr_sense, wr_req;
  logic          nmi_hit;

  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_sense = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_SENSE));
  assign wr_req   = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_REQ));

  // Selected polarity of the synchronised non-maskable pin.
  assign nmi_hit = edge_sel_q ? (nmi_cur & ~nmi_last) : (~nmi_cur & nmi_last);

  // A new request beats a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q    <= '0;
      req_q      <= '0;
      edge_sel_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (wr_sense) sense_q <= bus_wdata[SW-1:0];
      if (wr_ctrl) edge_sel_q <= bus_wdata[CTRL_EDGE_BIT];
      req_q  <= (wr_req ? (req_q & bus_wdata[N-1:0]) : req_q) | irq_hit;
      flag_q <= (wr_ctrl ? (flag_q & bus_wdata[CTRL_FLAG_BIT]) : flag_q) | nmi_hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[CTRL_LVL_BIT]  = nmi_cur;
        bus_rdata[CTRL_EDGE_BIT] = edge_sel_q;
        bus_rdata[CTRL_FLAG_BIT] = flag_q;
      end
      ADDR_W'(OFS_SENSE): bus_rdata[SW-1:0] = sense_q;
      ADDR_W'(OFS_REQ):   bus_rdata[N-1:0]  = req_q;
      default:            bus_rdata = '0;
    endcase
  end

  assign sense_flat = sense_q;
  assign req        = req_q;
  assign nmi_flag   = flag_q;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && irq_hit == '0) |=> req_q == $past(req_q));
  assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && irq_hit == '0) |=> req_q == ($past(req_q) & $past(bus_wdata[N-1:0])));
  assert_hit_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (req_q & $past(irq_hit)) == $past(irq_hit));
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[CTRL_FLAG_BIT] && !nmi_hit) |=> !flag_q);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !nmi_hit) |=> $stable(flag_q));
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_hit |=> flag_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic               nmi_pin,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_IRQ-1:0] irq_req,
  output logic               nmi_req
);
  localparam int unsigned PINS = NUM_IRQ + 1;

  logic [PINS-1:0]      s_cur, s_last;
  logic [NUM_IRQ-1:0]   hit;
  logic [2*NUM_IRQ-1:0] sense_flat;
  logic [NUM_IRQ-1:0]   req;
  logic                 flag;

  eirq_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in ({nmi_pin, irq_pin}),
    .cur    (s_cur),
    .last   (s_last)
  );

  eirq_detect #(.N(NUM_IRQ)) u_detect (
    .cur        (s_cur[NUM_IRQ-1:0]),
    .last       (s_last[NUM_IRQ-1:0]),
    .sense_flat (sense_flat),
    .hit        (hit)
  );

  eirq_regs #(.N(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_hit    (hit),
    .nmi_cur    (s_cur[NUM_IRQ]),
    .nmi_last   (s_last[NUM_IRQ]),
    .sense_flat (sense_flat),
    .req        (req),
    .nmi_flag   (flag)
  );

  assign irq_req = req;
  assign nmi_req = flag;

  // R11: outputs quiet while reset is held
  always_comb begin
    if (!rst_n) assert_quiet_in_reset_R11: assert (irq_req == '0 && !nmi_req);
  end
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [7:0]  irq_req;
  logic        nmi_req;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .nmi_req(nmi_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check("R11 irq_req in reset", {8'h0, irq_req}, 16'h0);
    check("R11 nmi_req in reset", {15'h0, nmi_req}, 16'h0);
    rd(3'd0, d); check("R11 ctrl in reset (pin high)", d, 16'h8000);
    rd(3'd2, d); check("R11 sense in reset", d, 16'h0);
    rd(3'd4, d); check("R11 req in reset", d, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    settle();
    check("R11 no request after release", {8'h0, irq_req}, 16'h0);
  endtask

  task automatic t_sense_cfg();
    logic [15:0] d;
    wr(3'd2, 16'hE4E4);
    rd(3'd2, d); check("R1 sense readback", d, 16'hE4E4);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    @(negedge clk); irq_pin = 8'h00;
    settle();
    // level ch0/4, falling ch1/5, both ch3/7
    check("R2 R3 R5 falling pattern irq_req R7", {8'h0, irq_req}, 16'h00BB);
    rd(3'd4, d); check("R6 req readback", d, 16'h00BB);
    wr(3'd4, 16'h0000);
    check("R2 level re-sets after clear", {8'h0, irq_req}, 16'h0011);
    @(negedge clk); irq_pin = 8'hFF;
    settle();
    check("R4 R5 rising pattern", {8'h0, irq_req}, 16'h00DD);
    wr(3'd4, 16'hFFFE);
    check("R6 single clear", {8'h0, irq_req}, 16'h00DC);
    wr(3'd4, 16'hFFFF);
    check("R6 ones keep", {8'h0, irq_req}, 16'h00DC);
    wr(3'd4, 16'h0000);
    rd(3'd4, d); check("R6 all cleared, upper zero", d, 16'h0000);
    @(negedge clk); irq_pin = 8'hDF;
    settle();
    check("R3 single falling pin 5", {8'h0, irq_req}, 16'h0020);
    wr(3'd4, 16'h0000);
    @(negedge clk); irq_pin = 8'hFF;
    settle();
    check("R3 falling mode ignores rise", {8'h0, irq_req}, 16'h0000);
  endtask

  task automatic t_latency();
    @(negedge clk); irq_pin = 8'hFB;
    settle();
    wr(3'd4, 16'h0000);
    check("R12 cleared before", {8'h0, irq_req}, 16'h0000);
    @(negedge clk); irq_pin = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 not after two edges", {15'h0, irq_req[2]}, 16'h0);
    @(negedge clk);
    check("R12 set after third edge", {15'h0, irq_req[2]}, 16'h1);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_nmi();
    logic [15:0] d;
    rd(3'd0, d); check("R8 level reads pin high", d, 16'h8000);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); check("R8 R10 ones write: only edge bit sticks", d, 16'h8100);
    wr(3'd0, 16'h0000);
    @(negedge clk); nmi_pin = 1'b0;
    settle();
    check("R9 falling edge sets flag R7", {15'h0, nmi_req}, 16'h1);
    rd(3'd0, d); check("R8 R9 ctrl after fall", d, 16'h0002);
    wr(3'd0, 16'h0002);
    check("R10 write 1 keeps flag", {15'h0, nmi_req}, 16'h1);
    wr(3'd0, 16'h0100);
    check("R10 write 0 clears flag", {15'h0, nmi_req}, 16'h0);
    @(negedge clk); nmi_pin = 1'b1;
    settle();
    rd(3'd0, d); check("R9 rising edge sets flag", d, 16'h8102);
    wr(3'd0, 16'h0100);
    @(negedge clk); nmi_pin = 1'b0;
    settle();
    rd(3'd0, d); check("R9 rising mode ignores fall", d, 16'h0100);
  endtask

  initial begin
    t_reset();
    t_sense_cfg();
    t_modes();
    t_latency();
    t_nmi();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule